// File: doc/BRIEF.md
# DAC Input Source Selector with Power-Up Settling

This block decides which 8-bit word each of two current-output DACs receives. It sits between a shared ADC, one 64-entry lookup table per channel and a set of control register bits. It also owns the power-up ordering of the surrounding analog circuits.

When the supply-good input rises, a sequencer runs a fixed order. It first issues a one-cycle recall strobe so the control registers can be loaded. It then enables the analog bias and waits a fixed settling time. Finally it waits for a second supply threshold before it enables the ADC. The DAC words stay at 00h until the ADC has produced a run of identical conversions. The run is four long by default, or a single conversion when the filter-disable input is set.

After release, each channel picks its own source by fixed priority:
1. a direct byte from its register;
2. a register-held 6-bit index into its lookup table;
3. the latest ADC result as that index (the default).

The lookup tables sit outside the block and answer one cycle after an address is presented. Dropping supply-good at any time sends the sequencer back to its off state and zeroes both DAC words.

Top module: `dac_input_select`

## Requirements
- R1: While rst_n is low, or while supply_ok is low, recall_o, analog_en_o and adc_en_o are 0 and both dac_word outputs are 00h.
- R2: After supply_ok rises, recall_o is 1 for exactly one cycle, one cycle after the rising edge is sampled. analog_en_o then stays 1 from the next cycle on. adc_en_o becomes 1 only after PWRUP_CYCLES cycles of analog settling, and only while adc_thresh_ok is 1. With adc_thresh_ok held at 0, adc_en_o stays 0.
- R3: With filt_off = 0, both dac_word outputs stay 00h until four consecutive adc_valid strobes (after adc_en_o is 1) carry the same adc_data value. The lookup path is released at the clock edge of the fourth strobe.
- R4: Each conversion that differs from the previous one starts a new run of length one. Runs interrupted this way never release, however many conversions are seen in total.
- R5: With filt_off = 1, the first adc_valid strobe after adc_en_o rises releases the lookup path.
- R6: After release, when direct_sel[c] is 1, dac_word[c] equals direct_byte[c], whatever index_sel[c] is.
- R7: After release, when direct_sel[c] is 0 and index_sel[c] is 1, lut_addr[c] equals reg_index[c] and dac_word[c] shows lut_rdata[c].
- R8: After release, when both select bits of a channel are 0, lut_addr[c] equals the adc_data of the latest adc_valid strobe and dac_word[c] shows lut_rdata[c]. It follows each new conversion.
- R9: Channel 0 and channel 1 use their own select bits, index, direct byte and table data. Any mix of sources across the two channels gives each channel its own result.
- R10: When supply_ok falls after release, both dac_word outputs are 00h and adc_en_o is 0 one cycle later. A new supply_ok rise restarts the whole sequence, filter included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | First supply threshold crossed |
| adc_thresh_ok | input | 1 | Second supply threshold crossed (ADC may run) |
| recall_o | output | 1 | One-cycle strobe to load control registers |
| analog_en_o | output | 1 | Analog bias enable |
| adc_en_o | output | 1 | ADC enable |
| adc_valid | input | 1 | One-cycle strobe marking a new conversion |
| adc_data | input | ADC_W | Conversion result |
| filt_off | input | 1 | 1: a single conversion releases the lookup path |
| direct_sel | input | NUM_CH | Per channel: drive the DAC from direct_byte |
| index_sel | input | NUM_CH | Per channel: index the table from reg_index |
| reg_index | input | NUM_CH x ADC_W | Per-channel register table index |
| direct_byte | input | NUM_CH x DAC_W | Per-channel register DAC byte |
| lut_addr | output | NUM_CH x ADC_W | Per-channel table address |
| lut_rdata | input | NUM_CH x DAC_W | Per-channel table data, one cycle after address |
| dac_word | output | NUM_CH x DAC_W | Per-channel DAC input word |

## Verification
A sequencer stuck in the wrong state, or a stability counter that miscounts, shows up as a DAC word that leaves 00h on the wrong conversion strobe. It can also show as one that never leaves 00h. Either is visible on the cycle after the deciding strobe.

A fault in the channel priority or in the index capture shows as a wrong lut_addr on the same cycle. It then shows as a wrong dac_word one cycle later, once the table answers. The bench mixes random conversion streams from a small value set with random source selections, so restart, saturation and priority are all hit repeatedly.

// File: rtl/dacsel_pkg.sv
// Shared types for the DAC input source selector.
// Assumes: consumers import this package; no state lives here.
package dacsel_pkg;

    // Power-up sequencer states, in the order they are visited.
    typedef enum logic [2:0] {
        SQ_OFF,
        SQ_RECALL,
        SQ_ANALOG,
        SQ_WAIT_ADC,
        SQ_FILTER,
        SQ_RUN
    } seq_state_t;

    // Per-channel DAC word source, highest priority last.
    typedef enum logic [1:0] {
        SRC_ADC,
        SRC_INDEX,
        SRC_DIRECT
    } src_t;

endpackage

// File: rtl/dacsel_stab.sv
// Stability filter: counts back-to-back identical conversions.
// Assumes: 'sample' is high only for valid strobes seen while filtering;
// 'clear' holds the counter at zero outside the filtering phase.
// 'hit_o' is combinational and true on the strobe that completes the run.
module dacsel_stab #(
    parameter int ADC_W    = 6,
    parameter int STABLE_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic [ADC_W-1:0] data,
    input  logic             filt_off,
    output logic             hit_o
);
    localparam int CNT_W = $clog2(STABLE_N + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_N);

    logic [CNT_W-1:0] cnt_q, cnt_nx, need;
    logic [ADC_W-1:0] last_q;

    // Next run length if the current sample is taken.
    always_comb begin
        if (cnt_q != '0 && data == last_q)
            cnt_nx = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        else
            cnt_nx = CNT_W'(1);
        need  = filt_off ? CNT_W'(1) : CNT_MAX;
        hit_o = sample && (cnt_nx >= need);
    end

    // Run-length counter and previous-value register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (sample) begin
            cnt_q  <= cnt_nx;
            last_q <= data;
        end
    end

    p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && sample && cnt_q != '0 && data != last_q) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/dacsel_seq.sv
// Power-up sequencer: off -> recall -> analog settle -> wait ADC threshold
// -> filter -> run. Loss of supply_ok returns to off from any state.
// Assumes: supply_ok and adc_thresh_ok are already synchronous to clk.
module dacsel_seq
    import dacsel_pkg::*;
#(
    parameter int PWRUP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic adc_thresh_ok,
    input  logic adc_valid,
    input  logic stable_hit,
    output logic recall_o,
    output logic analog_en_o,
    output logic adc_en_o,
    output logic filter_o,
    output logic run_o
);
    localparam int PW_W = $clog2(PWRUP_CYCLES) + 1;
    localparam logic [PW_W-1:0] PW_LAST = PW_W'(PWRUP_CYCLES - 1);

    seq_state_t state_q, state_nx;
    logic [PW_W-1:0] pw_cnt_q;

    // Next-state decision.
    always_comb begin
        state_nx = state_q;
        if (!supply_ok) begin
            state_nx = SQ_OFF;
        end else begin
            case (state_q)
                SQ_OFF:      state_nx = SQ_RECALL;
                SQ_RECALL:   state_nx = SQ_ANALOG;
                SQ_ANALOG:   if (pw_cnt_q == PW_LAST) state_nx = SQ_WAIT_ADC;
                SQ_WAIT_ADC: if (adc_thresh_ok) state_nx = SQ_FILTER;
                SQ_FILTER:   if (stable_hit) state_nx = SQ_RUN;
                SQ_RUN:      state_nx = SQ_RUN;
                default:     state_nx = SQ_OFF;
            endcase
        end
    end

    // State register and analog settling counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_OFF;
            pw_cnt_q <= '0;
        end else begin
            state_q  <= state_nx;
            pw_cnt_q <= (state_q == SQ_ANALOG && state_nx == SQ_ANALOG) ? pw_cnt_q + 1'b1 : '0;
        end
    end

    // Decoded enables.
    always_comb begin
        recall_o    = (state_q == SQ_RECALL);
        analog_en_o = (state_q == SQ_ANALOG) || (state_q == SQ_WAIT_ADC) ||
                      (state_q == SQ_FILTER) || (state_q == SQ_RUN);
        adc_en_o    = (state_q == SQ_FILTER) || (state_q == SQ_RUN);
        filter_o    = (state_q == SQ_FILTER);
        run_o       = (state_q == SQ_RUN);
    end

    p_recall_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (recall_o && supply_ok) |=> (!recall_o && analog_en_o));
    p_adc_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_en_o) |-> $past(adc_thresh_ok));
    p_supply_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state_q == SQ_OFF));
    p_release_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(adc_valid));

endmodule

// File: rtl/dacsel_chan.sv
// One DAC channel: picks the source by priority (direct byte, register
// index, ADC index) and forms the table address and DAC word.
// Assumes: the external table returns data one cycle after lut_addr;
// clk/rst_n are used only by the local assertions.
module dacsel_chan
    import dacsel_pkg::*;
#(
    parameter int ADC_W = 6,
    parameter int DAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             direct_sel,
    input  logic             index_sel,
    input  logic [ADC_W-1:0] reg_index,
    input  logic [DAC_W-1:0] direct_byte,
    input  logic [ADC_W-1:0] adc_idx,
    input  logic [DAC_W-1:0] lut_rdata,
    output logic [ADC_W-1:0] lut_addr,
    output logic [DAC_W-1:0] dac_word
);
    src_t src;

    // Source priority decode.
    always_comb begin
        if (direct_sel)     src = SRC_DIRECT;
        else if (index_sel) src = SRC_INDEX;
        else                src = SRC_ADC;
    end

    // Address and output word selection; zero until released.
    always_comb begin
        lut_addr = (src == SRC_INDEX) ? reg_index : adc_idx;
        if (!run)                   dac_word = '0;
        else if (src == SRC_DIRECT) dac_word = direct_byte;
        else                        dac_word = lut_rdata;
    end

    p_direct_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && direct_sel && index_sel) |-> (dac_word == direct_byte));
    p_index_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_sel && index_sel) |-> (lut_addr == reg_index));

endmodule

// File: rtl/dac_input_select.sv
// Top: power-up sequencer, shared ADC stability filter, latest-conversion
// register and one source selector per DAC channel.
// Assumes: all inputs synchronous to clk; tables live outside the block.
module dac_input_select #(
    parameter int ADC_W        = 6,
    parameter int DAC_W        = 8,
    parameter int NUM_CH       = 2,
    parameter int STABLE_N     = 4,
    parameter int PWRUP_CYCLES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           supply_ok,
    input  logic                           adc_thresh_ok,
    output logic                           recall_o,
    output logic                           analog_en_o,
    output logic                           adc_en_o,
    input  logic                           adc_valid,
    input  logic [ADC_W-1:0]               adc_data,
    input  logic                           filt_off,
    input  logic [NUM_CH-1:0]              direct_sel,
    input  logic [NUM_CH-1:0]              index_sel,
    input  logic [NUM_CH-1:0][ADC_W-1:0]   reg_index,
    input  logic [NUM_CH-1:0][DAC_W-1:0]   direct_byte,
    output logic [NUM_CH-1:0][ADC_W-1:0]   lut_addr,
    input  logic [NUM_CH-1:0][DAC_W-1:0]   lut_rdata,
    output logic [NUM_CH-1:0][DAC_W-1:0]   dac_word
);
    logic filtering, running, stable_hit;
    logic [ADC_W-1:0] adc_q;

    dacsel_seq #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .adc_thresh_ok(adc_thresh_ok), .adc_valid(adc_valid),
        .stable_hit(stable_hit), .recall_o(recall_o),
        .analog_en_o(analog_en_o), .adc_en_o(adc_en_o),
        .filter_o(filtering), .run_o(running)
    );

    dacsel_stab #(.ADC_W(ADC_W), .STABLE_N(STABLE_N)) u_stab (
        .clk(clk), .rst_n(rst_n), .clear(!filtering),
        .sample(adc_valid && filtering), .data(adc_data),
        .filt_off(filt_off), .hit_o(stable_hit)
    );

    // Latest conversion seen while the ADC is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                    adc_q <= '0;
        else if (adc_valid && adc_en_o) adc_q <= adc_data;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dacsel_chan #(.ADC_W(ADC_W), .DAC_W(DAC_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .run(running),
            .direct_sel(direct_sel[g]), .index_sel(index_sel[g]),
            .reg_index(reg_index[g]), .direct_byte(direct_byte[g]),
            .adc_idx(adc_q), .lut_rdata(lut_rdata[g]),
            .lut_addr(lut_addr[g]), .dac_word(dac_word[g])
        );

        p_dark_until_adc_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !adc_en_o |-> (dac_word[g] == '0));
    end

    p_adc_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_valid && adc_en_o && !direct_sel[0] && !index_sel[0])
        |=> (lut_addr[0] == $past(adc_data) || direct_sel[0] || index_sel[0]));

endmodule

// File: tb/dac_input_select_test.sv
`timescale 1ns/1ps
module dac_input_select_test;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, adc_thresh_ok = 1'b0;
    logic recall_o, analog_en_o, adc_en_o;
    logic adc_valid = 1'b0;
    logic [5:0] adc_data = '0;
    logic filt_off = 1'b0;
    logic [1:0] direct_sel = '0, index_sel = '0;
    logic [1:0][5:0] reg_index = '0;
    logic [1:0][7:0] direct_byte = '0;
    logic [1:0][5:0] lut_addr;
    logic [1:0][7:0] lut_rdata = '0;
    logic [1:0][7:0] dac_word;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [5:0] adc_last = '0;

    always #2.5 clk = ~clk;

    dac_input_select #(.PWRUP_CYCLES(PW)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .adc_thresh_ok(adc_thresh_ok),
        .recall_o(recall_o), .analog_en_o(analog_en_o), .adc_en_o(adc_en_o),
        .adc_valid(adc_valid), .adc_data(adc_data), .filt_off(filt_off),
        .direct_sel(direct_sel), .index_sel(index_sel), .reg_index(reg_index),
        .direct_byte(direct_byte), .lut_addr(lut_addr), .lut_rdata(lut_rdata),
        .dac_word(dac_word)
    );

    function automatic logic [7:0] lut_fn(int c, logic [5:0] idx);
        return 8'h80 | 8'((int'(idx) * 3 + c * 11) & 8'h7f);
    endfunction

    // External table model with one cycle of read latency.
    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) lut_rdata[c] <= lut_fn(c, lut_addr[c]);
    end

    function automatic logic [7:0] exp_dac(int c);
        if (direct_sel[c]) return direct_byte[c];
        if (index_sel[c])  return lut_fn(c, reg_index[c]);
        return lut_fn(c, adc_last);
    endfunction

    function automatic logic [5:0] exp_addr(int c);
        return index_sel[c] ? reg_index[c] : adc_last;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(logic [5:0] v);
        adc_data = v; adc_valid = 1'b1;
        @(negedge clk);
        adc_valid = 1'b0;
        if (adc_en_o) adc_last = v;
    endtask

    task automatic power_up();
        supply_ok = 1'b1; adc_thresh_ok = 1'b1;
        repeat (PW + 5) @(negedge clk);
    endtask

    task automatic power_down();
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 recall", recall_o, 0); chk("R1 adc_en", adc_en_o, 0);
        chk("R1 dac0", dac_word[0], 0); chk("R1 dac1", dac_word[1], 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 analog_en off", analog_en_o, 0);

        // R2: sequence with second threshold held low
        supply_ok = 1'b1;
        @(negedge clk); chk("R2 recall pulse", recall_o, 1);
        @(negedge clk); chk("R2 recall ends", recall_o, 0); chk("R2 analog on", analog_en_o, 1);
        repeat (PW + 10) @(negedge clk);
        chk("R2 adc held off", adc_en_o, 0);
        adc_thresh_ok = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 adc enabled", adc_en_o, 1);

        // R3: four identical conversions release
        send(6'd7); send(6'd7); send(6'd7);
        @(negedge clk);
        chk("R3 held after three", dac_word[0], 0);
        send(6'd7);
        @(negedge clk);
        chk("R3 released ch0", dac_word[0], lut_fn(0, 7));
        chk("R3 released ch1", dac_word[1], lut_fn(1, 7));

        // R10: supply loss
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R10 dac0 zero", dac_word[0], 0); chk("R10 adc off", adc_en_o, 0);

        // R4: interrupted runs never release
        power_up();
        for (int i = 0; i < 12; i++) send((i % 3 == 2) ? 6'd9 : 6'd4);
        @(negedge clk);
        chk("R4 interrupted runs", dac_word[0], 0);
        send(6'd9); send(6'd9); send(6'd9);
        @(negedge clk);
        chk("R4 run of four after restart", dac_word[0], lut_fn(0, 9));

        // R4 random: streams from two values against a bench run counter
        for (int t = 0; t < 6; t++) begin
            int cnt = 0;
            logic [5:0] prev = '0;
            bit rel = 0;
            power_down(); power_up();
            for (int i = 0; i < 40 && !rel; i++) begin
                logic [5:0] v = ($urandom % 2) ? 6'd5 : 6'd12;
                cnt = (cnt != 0 && v == prev) ? ((cnt < 4) ? cnt + 1 : 4) : 1;
                prev = v;
                send(v);
                @(negedge clk);
                rel = (cnt >= 4);
                chk("R4 random filter", dac_word[0], rel ? lut_fn(0, v) : 0);
            end
        end

        // R5: filter disabled
        power_down();
        filt_off = 1'b1;
        power_up();
        @(negedge clk);
        chk("R5 held before strobe", dac_word[1], 0);
        send(6'd33);
        @(negedge clk);
        chk("R5 single strobe", dac_word[1], lut_fn(1, 33));
        filt_off = 1'b0;

        // R6/R7/R9 directed mix
        direct_sel = 2'b01; index_sel = 2'b11;
        direct_byte[0] = 8'h3c; reg_index[1] = 6'd50;
        repeat (2) @(negedge clk);
        chk("R6 direct over index", dac_word[0], 8'h3c);
        chk("R7 index addr", lut_addr[1], 50);
        chk("R9 ch1 independent", dac_word[1], lut_fn(1, 50));

        // R8: default path follows new conversions
        direct_sel = 2'b00; index_sel = 2'b00;
        send(6'd21);
        @(negedge clk);
        chk("R8 addr follows adc", lut_addr[0], 21);
        chk("R8 dac follows adc", dac_word[1], lut_fn(1, 21));

        // R6-R9 random mixing
        for (int i = 0; i < 60; i++) begin
            direct_sel = 2'($urandom); index_sel = 2'($urandom);
            for (int c = 0; c < 2; c++) begin
                reg_index[c] = 6'($urandom); direct_byte[c] = 8'($urandom);
            end
            if ($urandom % 2) send(6'($urandom));
            repeat (2) @(negedge clk);
            for (int c = 0; c < 2; c++) begin
                chk("R9 random dac", dac_word[c], exp_dac(c));
                if (!direct_sel[c]) chk("R7 R8 random addr", lut_addr[c], exp_addr(c));
            end
        end

        // R10: drop and restart requires the filter again
        power_down();
        chk("R10 zero after drop", dac_word[1], 0);
        direct_sel = 2'b00; index_sel = 2'b00;
        power_up();
        send(6'd2); send(6'd2);
        @(negedge clk);
        chk("R10 filter re-armed", dac_word[0], 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule